// File: doc/BRIEF.md
# Quad Periodic Interrupt Timer

This block holds four down-counting timer channels behind a small word-addressed register bus. Software turns on the module-level run bit, sets up each channel's reload value and control word, and arms the channels. In compare mode a channel counts down from its reload value and produces a timeout each time it passes zero. In capture mode the channel counts down freely, and a trigger input copies the live count into the channel's reload register for software to read. A channel can be linked to the channel below it. It then counts only once per timeout of that lower channel, which gives longer periods.

Each timeout sets a sticky flag that software clears by writing one to it. Flags pass through per-channel enables into one interrupt line. While the run bit is off, the timer logic is halted and most registers refuse writes with a transfer-error pulse. After the run bit is set, the timers stay idle for four cycles before they count.

Bus timing: a write or read strobe is sampled at a clock edge. Read data and the error pulse appear on the registered outputs after that edge. Word addresses: 0 control, 1 flags, 2 interrupt enables, 3 arm-set, 4 arm-clear. Channel n uses 8+4n (reload), 9+4n (live count) and 10+4n (control word).

Top module: `pit_quad`

## Requirements
- R1: After reset, every register reads 0. `rdata_o`, `err_o` and `irq_o` are 0.
- R2: The control register (address 0: bit 0 run, bits 1 and 2 plain storage) and the interrupt-enable register (address 2) accept writes at all times. The other writable registers are flags (1), arm-set (3), arm-clear (4), reload (8+4n) and channel control (10+4n). While run is 0, a write to any of them raises `err_o` for one cycle and changes nothing.
- R3: A write to a live-count address (9+4n), to 5..7, to 11+4n, or to any address at or above 24 always raises `err_o` and changes nothing.
- R4: A read never raises `err_o`. Its data appears on `rdata_o` one cycle after the strobe. Reserved addresses read 0.
- R5: After the write that sets run, counters stay still for four cycles. The first count step happens on the fifth clock edge after that write.
- R6: Channel control word: bit 0 enable, bit 1 link, bits 3:2 mode (01 capture, any other value compare), bits 15:8 trigger setup storage. An enabled compare channel with reload L steps L, L-1, ..., 0, L, ... once per cycle and times out on the step from 0.
- R7: A disabled channel's live count equals its reload value. An enabled channel's count stays still while run is 0.
- R8: A linked channel n>0 steps only in cycles where channel n-1 times out.
- R9: Channel 0 ignores its link bit and steps every cycle.
- R10: In capture mode, a high `trig_i[n]` copies the count held before that edge into reload register n. It also sets flag n and reloads the count with all ones.
- R11: A timeout sets flag n (bit n of address 1). Writing 1 clears the bit, and writing 0 leaves it. A timeout in the same cycle as a clear leaves the flag set.
- R12: `irq_o` is the registered OR of flags ANDed with the interrupt enables (bit n of address 2). It follows them one cycle later.
- R13: Writing 1s to arm-set (3) or arm-clear (4) sets or clears the matching channel enable bits. Reading either address returns the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| trig_i | input | NCH (4) | Per-channel capture trigger |
| rdata_o | output | DATA_W (32) | Registered read data |
| err_o | output | 1 | One-cycle transfer-error pulse after a refused write |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sends random writes to every address while the module is off and random writes to forbidden addresses while it is on. A design that mixed up the gated and ungated register sets would report the wrong error or let a refused write land. It streams the live count on every cycle to check reload order and linked pacing. A counter that reloads one step early, or a linked channel that paces off the wrong channel, breaks the sequence or the five-cycle gap between steps. It counts the idle cycles after the run bit is set, which exposes a warm-up window that is too short or too long. It fires a capture trigger alongside a read of the count, which catches a capture that takes the value one cycle late. A clear issued while a channel is timing out every cycle shows whether the flag clear wrongly beats a new timeout.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_FLAGS   = 1;
  localparam int unsigned A_IEN     = 2;
  localparam int unsigned A_ARMSET  = 3;
  localparam int unsigned A_ARMCLR  = 4;
  localparam int unsigned A_CH_BASE = 8;
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned OFF_LOAD  = 0;
  localparam int unsigned OFF_COUNT = 1;
  localparam int unsigned OFF_CFG   = 2;

  typedef enum logic [1:0] {
    MODE_CMP  = 2'b00,
    MODE_CAP  = 2'b01,
    MODE_RES2 = 2'b10,
    MODE_RES3 = 2'b11
  } mode_e;
endpackage

// File: rtl/pit_bus.sv
module pit_bus
  import pit_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int NCH    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           run,
  input  logic [DATA_W-1:0]              ctrl_word,
  input  logic [NCH-1:0]                 flags,
  input  logic [NCH-1:0]                 ien,
  input  logic [NCH-1:0]                 arm,
  input  logic [NCH-1:0][DATA_W-1:0]     load_v,
  input  logic [NCH-1:0][DATA_W-1:0]     count_v,
  input  logic [NCH-1:0][DATA_W-1:0]     cfg_v,
  output logic                           wr_ctrl,
  output logic                           wr_flags,
  output logic                           wr_ien,
  output logic                           wr_armset,
  output logic                           wr_armclr,
  output logic [NCH-1:0]                 wr_load,
  output logic [NCH-1:0]                 wr_cfg,
  output logic [DATA_W-1:0]              rdata,
  output logic                           err
);
  logic [31:0] a32;
  logic hit_ctrl, hit_flags, hit_ien, hit_set, hit_clr;
  logic [NCH-1:0] hit_load, hit_cnt, hit_cfg;
  logic gated, free, ok_now;
  logic [DATA_W-1:0] rsel;

  assign a32 = 32'(addr);

  always_comb begin
    hit_ctrl  = (a32 == A_CTRL);
    hit_flags = (a32 == A_FLAGS);
    hit_ien   = (a32 == A_IEN);
    hit_set   = (a32 == A_ARMSET);
    hit_clr   = (a32 == A_ARMCLR);
    for (int i = 0; i < NCH; i++) begin
      hit_load[i] = (a32 == 32'(A_CH_BASE + i*CH_STRIDE + OFF_LOAD));
      hit_cnt[i]  = (a32 == 32'(A_CH_BASE + i*CH_STRIDE + OFF_COUNT));
      hit_cfg[i]  = (a32 == 32'(A_CH_BASE + i*CH_STRIDE + OFF_CFG));
    end
  end

  always_comb begin
    gated  = hit_flags | hit_set | hit_clr | (|hit_load) | (|hit_cfg);
    free   = hit_ctrl | hit_ien;
    ok_now = free | (gated & run);
  end

  assign wr_ctrl   = wr & hit_ctrl;
  assign wr_ien    = wr & hit_ien;
  assign wr_flags  = wr & run & hit_flags;
  assign wr_armset = wr & run & hit_set;
  assign wr_armclr = wr & run & hit_clr;
  assign wr_load   = {NCH{wr & run}} & hit_load;
  assign wr_cfg    = {NCH{wr & run}} & hit_cfg;

  always_comb begin
    rsel = '0;
    if (hit_ctrl)  rsel = ctrl_word;
    if (hit_flags) rsel[NCH-1:0] = flags;
    if (hit_ien)   rsel[NCH-1:0] = ien;
    if (hit_set | hit_clr) rsel[NCH-1:0] = arm;
    for (int i = 0; i < NCH; i++) begin
      if (hit_load[i]) rsel = load_v[i];
      if (hit_cnt[i])  rsel = count_v[i];
      if (hit_cfg[i])  rsel = cfg_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= wr & ~ok_now;
      if (rd) rdata <= rsel;
    end
  end
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              link_tmo,
  input  logic              trig,
  input  logic              wr_load,
  input  logic              wr_cfg,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] cfg_word,
  output logic              on_q,
  output logic              tmo
);
  localparam bit CAN_LINK = (IDX > 0);
  localparam logic [DATA_W-1:0] TOP = '1;

  logic        link_q;
  mode_e       mode_q;
  logic [7:0]  trg_q;
  logic        is_cap, pace, step, cap_evt, wrap;

  always_comb begin
    is_cap  = (mode_q == MODE_CAP);
    pace    = (CAN_LINK && link_q) ? link_tmo : 1'b1;
    cap_evt = go & on_q & is_cap & trig;
    step    = go & on_q & pace & ~cap_evt;
    wrap    = step & (count_q == '0);
    tmo     = cap_evt | wrap;
  end

  always_comb begin
    cfg_word       = '0;
    cfg_word[0]    = on_q;
    cfg_word[1]    = link_q;
    cfg_word[3:2]  = mode_q;
    cfg_word[15:8] = trg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      link_q <= 1'b0;
      mode_q <= MODE_CMP;
      trg_q  <= '0;
    end else if (wr_cfg) begin
      on_q   <= wdata[0];
      link_q <= wdata[1];
      mode_q <= mode_e'(wdata[3:2]);
      trg_q  <= wdata[15:8];
    end else if (arm_set) begin
      on_q <= 1'b1;
    end else if (arm_clr) begin
      on_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
    end else if (cap_evt) begin
      load_q <= count_q;
    end else if (wr_load) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!on_q) begin
      count_q <= load_q;
    end else if (cap_evt) begin
      count_q <= TOP;
    end else if (wrap) begin
      count_q <= is_cap ? TOP : load_q;
    end else if (step) begin
      count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/pit_flags.sv
module pit_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set,
  input  logic           wr_flags,
  input  logic           wr_ien,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] flags_q,
  output logic [NCH-1:0] ien_q,
  output logic           irq
);
  logic [NCH-1:0] clr;

  assign clr = wr_flags ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      ien_q   <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr) | set;
      if (wr_ien) ien_q <= wbits;
      irq <= |(flags_q & ien_q);
    end
  end
endmodule

// File: rtl/pit_quad.sv
module pit_quad
  import pit_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int WARM   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCH-1:0]    trig_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_o
);
  localparam int WW = $clog2(WARM + 1);

  logic run_q, halt_q, nap_q;
  logic [WW-1:0] warm_q;
  logic go;
  logic [DATA_W-1:0] ctrl_word;
  logic wr_ctrl, wr_flags, wr_ien, wr_armset, wr_armclr;
  logic [NCH-1:0] wr_load, wr_cfg, arm_v, tmo_v, flags_q, ien_q;
  logic [NCH-1:0][DATA_W-1:0] load_v, count_v, cfg_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      halt_q <= 1'b0;
      nap_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wdata_i[0];
      halt_q <= wdata_i[1];
      nap_q  <= wdata_i[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_q) warm_q <= '0;
    else if (warm_q != WW'(WARM)) warm_q <= warm_q + 1'b1;
  end

  assign go = run_q & (warm_q == WW'(WARM));

  always_comb begin
    ctrl_word    = '0;
    ctrl_word[0] = run_q;
    ctrl_word[1] = halt_q;
    ctrl_word[2] = nap_q;
  end

  pit_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_bus (
    .clk(clk), .rst(rst), .wr(wr_i), .rd(rd_i), .addr(addr_i), .run(run_q),
    .ctrl_word(ctrl_word), .flags(flags_q), .ien(ien_q), .arm(arm_v),
    .load_v(load_v), .count_v(count_v), .cfg_v(cfg_v),
    .wr_ctrl(wr_ctrl), .wr_flags(wr_flags), .wr_ien(wr_ien),
    .wr_armset(wr_armset), .wr_armclr(wr_armclr),
    .wr_load(wr_load), .wr_cfg(wr_cfg), .rdata(rdata_o), .err(err_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic tmo, link_in;
    if (i == 0) begin : g_first
      assign link_in = 1'b0;
    end else begin : g_next
      assign link_in = g_ch[i-1].tmo;
    end
    pit_chan #(.DATA_W(DATA_W), .IDX(i)) u_chan (
      .clk(clk), .rst(rst), .go(go), .link_tmo(link_in), .trig(trig_i[i]),
      .wr_load(wr_load[i]), .wr_cfg(wr_cfg[i]),
      .arm_set(wr_armset & wdata_i[i]), .arm_clr(wr_armclr & wdata_i[i]),
      .wdata(wdata_i), .load_q(load_v[i]), .count_q(count_v[i]),
      .cfg_word(cfg_v[i]), .on_q(arm_v[i]), .tmo(tmo)
    );
    assign tmo_v[i] = tmo;
  end

  pit_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .set(tmo_v), .wr_flags(wr_flags), .wr_ien(wr_ien),
    .wbits(wdata_i[NCH-1:0]), .flags_q(flags_q), .ien_q(ien_q), .irq(irq_o)
  );
endmodule

// File: rtl/pit_quad_chk.sv
module pit_quad_chk
  import pit_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NCH    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NCH-1:0]    wbits,
  input logic              err_o,
  input logic              irq_o,
  input logic              run_q,
  input logic              go,
  input logic [NCH-1:0]    flags_q,
  input logic [NCH-1:0]    ien_q
);
  localparam int unsigned CH_END = A_CH_BASE + NCH * CH_STRIDE;
  logic [31:0] a32;
  logic bad_addr;

  assign a32 = 32'(addr_i);

  always_comb begin
    if (a32 < A_CH_BASE)   bad_addr = (a32 > A_ARMCLR);
    else if (a32 < CH_END) bad_addr = (a32[1:0] == 2'(OFF_COUNT)) || (a32[1:0] == 2'd3);
    else                   bad_addr = 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!err_o && !irq_o)); // R1
  AST_OFF_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !run_q && a32 == A_FLAGS) |=> err_o); // R2
  AST_CTRL_FREE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && a32 == A_CTRL) |=> !err_o); // R2
  AST_BAD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && bad_addr) |=> err_o); // R3
  AST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> !err_o); // R4
  AST_WARM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |=> !go); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq_o); // R12

  for (genvar i = 0; i < NCH; i++) begin : g_keep
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !(wr_i && run_q && a32 == A_FLAGS && wbits[i])) |=> flags_q[i]); // R11
  end
endmodule

bind pit_quad pit_quad_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) i_chk (
  .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wbits(wdata_i[NCH-1:0]), .err_o(err_o), .irq_o(irq_o), .run_q(run_q),
  .go(go), .flags_q(flags_q), .ien_q(ien_q)
);

// File: tb/test_pit_quad.sv
module test_pit_quad;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] trig = '0;
  logic [31:0] rdata;
  logic err, irq;
  int checks = 0, fails = 0;
  logic [31:0] smp [64];

  localparam int unsigned CTRL = 0, FLAGS = 1, IEN = 2, ASET = 3, ACLR = 4;

  always #5 clk = ~clk;

  pit_quad i_pit_quad (
    .clk(clk), .rst(rst), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .trig_i(trig), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  function automatic int unsigned ld(int n);  return 8 + 4*n;  endfunction
  function automatic int unsigned cnt(int n); return 9 + 4*n;  endfunction
  function automatic int unsigned cfg(int n); return 10 + 4*n; endfunction

  function automatic bit gated_addr(int unsigned a);
    return (a == FLAGS) || (a == ASET) || (a == ACLR) ||
           (a >= 8 && a < 24 && (a % 4 == 0 || a % 4 == 2));
  endfunction

  function automatic bit exp_err(int unsigned a, bit run);
    if (a == CTRL || a == IEN) return 1'b0;
    if (gated_addr(a)) return !run;
    return 1'b1;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] v, logic [31:0] l);
    return (v == 0) ? l : v - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int unsigned a, input logic [31:0] d, output logic e);
    @(negedge clk); wr = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk); wr = 1'b0; e = err;
  endtask

  task automatic bus_rd(input int unsigned a, output logic [31:0] d, output logic e);
    @(negedge clk); rd = 1'b1; addr = 6'(a);
    @(negedge clk); rd = 1'b0; d = rdata; e = err;
  endtask

  task automatic stream(input int unsigned a, input int n);
    @(negedge clk); rd = 1'b1; addr = 6'(a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); smp[k] = rdata;
    end
    rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic e;
    logic [31:0] d, f, g, cap;
    int unsigned a;
    int last, nchg;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq == 0 && err == 0 && rdata == 0, "R1 outputs", {rdata[29:0], irq, err}, 0);
    foreach (smp[k]) smp[k] = '0;
    for (int i = 0; i < 3; i++) begin
      bus_rd(i, d, e); chk(d == 0, "R1 reg", d, 0);
    end
    bus_rd(ld(0), d, e); chk(d == 0, "R1 load", d, 0);
    bus_rd(cfg(3), d, e); chk(d == 0, "R1 cfg", d, 0);

    // R2 random writes while off
    for (int k = 0; k < 40; k++) begin
      a = 1 + $urandom_range(0, 30);
      bus_wr(a, $urandom, e);
      chk(e == exp_err(a, 0), "R2 off error", e, exp_err(a, 0));
    end
    bus_wr(IEN, 32'hA, e); chk(e == 0, "R2 ien free", e, 0);
    bus_rd(IEN, d, e); chk(d == 32'hA && e == 0, "R4 read while off", d, 32'hA);
    bus_wr(IEN, 0, e);
    for (int n = 0; n < 4; n++) begin
      bus_rd(ld(n), d, e);  chk(d == 0, "R2 load untouched", d, 0);
      bus_rd(cfg(n), d, e); chk(d == 0, "R2 cfg untouched", d, 0);
    end
    bus_rd(FLAGS, d, e); chk(d == 0, "R2 flags untouched", d, 0);
    bus_rd(ASET, d, e);  chk(d == 0, "R2 arm untouched", d, 0);

    // R3 forbidden writes while on
    bus_wr(CTRL, 1, e); chk(e == 0, "R2 ctrl free", e, 0);
    for (int k = 0; k < 30; k++) begin
      do a = 5 + $urandom_range(0, 58); while (!exp_err(a, 1));
      bus_wr(a, $urandom, e);
      chk(e == 1, "R3 forbidden write", e, 1);
    end
    bus_rd(ld(1), d, e); chk(d == 0, "R3 no effect", d, 0);
    bus_rd(40, d, e); chk(d == 0 && e == 0, "R4 reserved read", d, 0);

    // R6 compare stepping
    bus_wr(ld(0), 4, e); chk(e == 0, "R2 load on", e, 0);
    bus_wr(cfg(0), 1, e);
    stream(cnt(0), 20);
    for (int k = 1; k < 20; k++)
      chk(smp[k] == nxt(smp[k-1], 4), "R6 sequence", smp[k], nxt(smp[k-1], 4));
    bus_rd(FLAGS, d, e); chk(d[0] == 1, "R11 flag on timeout", d, 1);

    // R7 disabled channel tracks reload
    bus_wr(ld(1), 7, e);
    repeat (2) @(negedge clk);
    bus_rd(cnt(1), d, e); chk(d == 7, "R7 disabled count", d, 7);

    // R8 linked pacing
    bus_wr(cfg(1), 3, e);
    stream(cnt(1), 40);
    last = -1; nchg = 0;
    for (int k = 1; k < 40; k++) begin
      if (smp[k] != smp[k-1]) begin
        chk(smp[k] == nxt(smp[k-1], 7), "R8 linked value", smp[k], nxt(smp[k-1], 7));
        if (last >= 0) chk(k - last == 5, "R8 linked gap", k - last, 5);
        last = k; nchg++;
      end
    end
    chk(nchg >= 6, "R8 linked steps", nchg, 6);

    // R9 channel 0 ignores link bit
    bus_wr(cfg(0), 3, e);
    stream(cnt(0), 8);
    for (int k = 1; k < 8; k++)
      chk(smp[k] == nxt(smp[k-1], 4), "R9 channel 0 free", smp[k], nxt(smp[k-1], 4));

    // R7 freeze while off, R5 warm-up
    bus_wr(CTRL, 0, e);
    bus_rd(cnt(0), f, e);
    repeat (3) @(negedge clk);
    bus_rd(cnt(0), g, e); chk(f == g, "R7 frozen while off", g, f);
    @(negedge clk); wr = 1'b1; addr = 6'(CTRL); wdata = 1;
    @(negedge clk); wr = 1'b0; rd = 1'b1; addr = 6'(cnt(0));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); smp[k] = rdata;
    end
    rd = 1'b0;
    for (int k = 0; k < 5; k++) chk(smp[k] == f, "R5 warm-up idle", smp[k], f);
    chk(smp[5] == nxt(f, 4), "R5 first step", smp[5], nxt(f, 4));

    // R12 interrupt gating
    bus_wr(IEN, 1, e); @(negedge clk);
    chk(irq == 1, "R12 irq on", irq, 1);
    bus_wr(IEN, 0, e); @(negedge clk);
    chk(irq == 0, "R12 irq off", irq, 0);

    // R11 write 0 keeps, set beats clear
    bus_wr(FLAGS, 0, e);
    bus_rd(FLAGS, d, e); chk(d[0] == 1, "R11 write zero", d[0], 1);
    bus_wr(ld(0), 0, e);
    repeat (8) @(negedge clk);
    bus_wr(FLAGS, 1, e);
    bus_rd(FLAGS, d, e); chk(d[0] == 1, "R11 set wins", d[0], 1);

    // R13 arm alias
    bus_wr(ACLR, 3, e);
    bus_rd(cfg(0), d, e); chk(d[0] == 0, "R13 arm clear", d[0], 0);
    bus_rd(ASET, d, e);   chk(d[3:0] == 0, "R13 arm read", d[3:0], 0);
    bus_wr(FLAGS, 1, e);
    bus_rd(FLAGS, d, e); chk(d[0] == 0, "R11 clear", d[0], 0);
    bus_wr(ASET, 1, e);
    bus_rd(cfg(0), d, e); chk(d[0] == 1, "R13 arm set", d[0], 1);
    bus_wr(ACLR, 1, e);

    // R10 capture
    bus_wr(ld(2), 1000, e);
    bus_wr(cfg(2), 32'h0000_AB05, e);
    repeat (3) @(negedge clk);
    @(negedge clk); rd = 1'b1; addr = 6'(cnt(2)); trig = 4'b0100;
    @(negedge clk); trig = '0; cap = rdata;
    @(negedge clk); d = rdata; rd = 1'b0;
    chk(cap < 1000 && cap != 0, "R10 captured range", cap, 1000);
    chk(d == 32'hFFFF_FFFF, "R10 reload all ones", d, 32'hFFFF_FFFF);
    bus_rd(ld(2), d, e); chk(d == cap, "R10 captured value", d, cap);
    bus_rd(FLAGS, d, e); chk(d[2] == 1, "R10 capture flag", d[2], 1);
    bus_rd(cfg(2), d, e); chk(d == 32'h0000_AB05, "R6 cfg fields", d, 32'h0000_AB05);

    // R2 refusal while off keeps captured value, R4 read while off
    bus_wr(CTRL, 0, e);
    bus_wr(ld(2), 5, e); chk(e == 1, "R2 load refused", e, 1);
    bus_rd(ld(2), d, e); chk(d == cap && e == 0, "R4 read off", d, cap);
    bus_rd(CTRL, d, e); chk(d == 0, "R2 ctrl readback", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule